// File: doc/BRIEF.md
# Micro-Packet Transport Stream Reassembler

This block accepts a stream of 32-bit micro-packets in which up to four transport streams are interleaved. Each word carries a stream tag, a packet-start flag, a device-overflow flag, a 3-bit rolling sequence number and three payload bytes. The block keeps a small amount of state for each stream: a fragment index, whether a packet is open, and the last sequence value. It sorts each accepted word to its stream and sends the payload bytes out one at a time. Every 188-byte packet is marked with start-of-packet and end-of-packet.

A packet is built from 63 fragments. The first 62 fragments give three bytes each. The 63rd gives only two, which makes 188 bytes. Bytes leave on an 8-bit valid/ready port together with the stream number. The block stores nothing beyond the fragment currently being sent, so the input is held off while those bytes drain.

The block raises two kinds of per-stream event. A one-cycle pulse appears on a loss vector when a sequence number breaks the modulo-8 progression. A one-cycle pulse appears on an overflow vector when the device reports that its buffer overflowed.

Top module: `mpkt_ts_rebuild`

## Requirements
- R1: The tag in bits 31:29 selects the stream. A tag of 1, 2, 3 or 4 means stream 0, 1, 2 or 3. A word with a tag of 0, 5, 6 or 7 is accepted and discarded: it produces no output byte and no pulse.
- R2: When bit 25 (start) is set, the stream's fragment index goes to 0 and a new packet begins. This also applies in the middle of a packet. The first byte of that fragment is marked out_sop.
- R3: A stream that is idle discards a fragment without the start flag, and no pulse follows. A stream is idle after reset and again after its 63rd fragment.
- R4: A kept fragment raises loss_pulse[s] for exactly one cycle, in the cycle after it is accepted, when its sequence number (bits 28:26) is not the stream's previous sequence value plus one, modulo 8. The first kept fragment of a stream after reset is never flagged. Discarded fragments do not change the stored sequence value.
- R5: A kept fragment with bit 24 set raises ovf_pulse[s] for exactly one cycle, in the cycle after it is accepted. A discarded fragment raises no pulse.
- R6: The bytes of a kept fragment leave in the order of bits 23:16, then 15:8, then 7:0, with out_sid set to the stream number. Fragment index 62 (the 63rd fragment) sends only bits 23:16 and 15:8.
- R7: out_sop marks the first byte of fragment index 0. out_eop marks the last byte of fragment index 62. A complete packet is therefore 188 bytes.
- R8: A word is accepted when in_valid and in_ready are both high. in_ready is low while any byte of the previous fragment is still waiting to leave.
- R9: While out_valid is high and out_ready is low, out_valid, out_byte, out_sid, out_sop and out_eop stay unchanged.
- R10: After reset, out_valid is low, in_ready is high, both pulse vectors are zero, and every stream is idle with no sequence history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-packet word present |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Micro-packet word |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Payload byte |
| out_sid | output | SID_W (2) | Stream number of the byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| loss_pulse | output | N_STREAMS (4) | Per-stream sequence-break pulse |
| ovf_pulse | output | N_STREAMS (4) | Per-stream device-overflow pulse |

## Verification
A full directed 63-fragment packet on one stream shows whether the two-byte final fragment and the sop/eop marks line up into exactly 188 bytes. Words with illegal tags, and non-start words sent to idle streams, separate the kept fragments from the discarded ones. A mid-packet restart shows that the fragment index really resets. Long random mixes of all four streams then check per-stream isolation of the index and sequence state, using occasional sequence jumps, overflow flags and random output back-pressure. A held-off output shows that the input stalls and the byte stays stable.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   // Field layout of one 32-bit micro-packet word, most significant first.
   typedef struct packed {
      logic [2:0]  tag;      // stream number plus one
      logic [2:0]  seq;      // rolling sequence value
      logic        first;    // opens a packet
      logic        dev_ovf;  // device buffer overflowed
      logic [23:0] pay;      // three payload bytes, top byte sent first
   } mpkt_t;

   localparam int FRAG_BYTES = 3;
   localparam int SEQ_W      = 3;

endpackage

// File: rtl/mpr_tag_decode.sv
module mpr_tag_decode #(
   parameter int N_STREAMS = 4,
   parameter int SID_W     = 2
) (
   input  logic [2:0]           tag,
   output logic                 hit,
   output logic [SID_W-1:0]     sid,
   output logic [N_STREAMS-1:0] onehot
);

   always_comb begin
      hit    = (tag != 3'd0) && (int'(tag) <= N_STREAMS);
      onehot = hit ? (N_STREAMS'(1) << (tag - 3'd1)) : '0;
   end

   generate
      if (N_STREAMS == 1) begin : g_single
         assign sid = '0;
      end else begin : g_multi
         assign sid = hit ? SID_W'(tag - 3'd1) : '0;
      end
   endgenerate

endmodule

// File: rtl/mpr_stream_ctx.sv
module mpr_stream_ctx #(
   parameter int FRAGS_PER_PKT = 63,
   parameter int CNT_W         = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,      // accepted word addressed to this stream
   input  logic             first,
   input  logic [2:0]       seq,
   output logic             keep,      // this stream would keep the word
   output logic [CNT_W-1:0] frag_idx,  // index the word lands on
   output logic             loss_ev
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAGS_PER_PKT - 1);

   logic             open_q;
   logic             seen_q;
   logic [2:0]       last_q;
   logic [CNT_W-1:0] idx_q;

   assign keep     = first || open_q;
   assign frag_idx = first ? '0 : idx_q;
   assign loss_ev  = take && keep && seen_q && (seq != 3'(last_q + 3'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         seen_q <= 1'b0;
         last_q <= '0;
         idx_q  <= '0;
      end else if (take && keep) begin
         seen_q <= 1'b1;
         last_q <= seq;
         if (frag_idx == LAST_IDX) begin
            idx_q  <= '0;
            open_q <= 1'b0;
         end else begin
            idx_q  <= frag_idx + CNT_W'(1);
            open_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mpr_byte_ser.sv
module mpr_byte_ser #(
   parameter int SID_W = 2,
   parameter int FB    = 3,
   parameter int NB_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [8*FB-1:0]   pay,
   input  logic [NB_W-1:0]   nbytes,
   input  logic [SID_W-1:0]  sid,
   input  logic              sop,
   input  logic              eop,
   output logic              empty,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_byte,
   output logic [SID_W-1:0]  out_sid,
   output logic              out_sop,
   output logic              out_eop
);

   logic [8*FB-1:0]  data_q;
   logic [NB_W-1:0]  rem_q;
   logic [SID_W-1:0] sid_q;
   logic             sop_q;
   logic             eop_q;
   logic             xfer;

   assign empty     = (rem_q == '0);
   assign out_valid = !empty;
   assign xfer      = out_valid && out_ready;
   assign out_byte  = data_q[8*FB-1 -: 8];
   assign out_sid   = sid_q;
   assign out_sop   = sop_q;
   assign out_eop   = eop_q && (rem_q == NB_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         rem_q  <= '0;
         sid_q  <= '0;
         sop_q  <= 1'b0;
         eop_q  <= 1'b0;
      end else if (load) begin
         data_q <= pay;
         rem_q  <= nbytes;
         sid_q  <= sid;
         sop_q  <= sop;
         eop_q  <= eop;
      end else if (xfer) begin
         data_q <= data_q << 8;
         rem_q  <= rem_q - NB_W'(1);
         sop_q  <= 1'b0;
      end
   end

endmodule

// File: rtl/mpkt_ts_rebuild.sv
module mpkt_ts_rebuild #(
   parameter  int N_STREAMS     = 4,
   parameter  int FRAGS_PER_PKT = 63,
   parameter  int LAST_BYTES    = 2,
   localparam int SID_W         = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [31:0]          in_word,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [7:0]           out_byte,
   output logic [SID_W-1:0]     out_sid,
   output logic                 out_sop,
   output logic                 out_eop,
   output logic [N_STREAMS-1:0] loss_pulse,
   output logic [N_STREAMS-1:0] ovf_pulse
);
   import mpr_pkg::*;

   localparam int               CNT_W    = $clog2(FRAGS_PER_PKT);
   localparam int               NB_W     = $clog2(FRAG_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAGS_PER_PKT - 1);

   generate
      if (N_STREAMS < 1 || N_STREAMS > 7) begin : g_bad_streams
         $error("N_STREAMS must fit a 3-bit tag (1..7)");
      end
      if (FRAGS_PER_PKT < 2) begin : g_bad_frags
         $error("FRAGS_PER_PKT must be at least 2");
      end
      if (LAST_BYTES < 1 || LAST_BYTES > FRAG_BYTES) begin : g_bad_last
         $error("LAST_BYTES must be 1..FRAG_BYTES");
      end
   endgenerate

   mpkt_t                 frag;
   logic                  acc;
   logic                  hit;
   logic [SID_W-1:0]      dsid;
   logic [N_STREAMS-1:0]  dsel;
   logic [N_STREAMS-1:0]  take_v;
   logic [N_STREAMS-1:0]  keep_v;
   logic [N_STREAMS-1:0]  loss_v;
   logic [CNT_W-1:0]      idx_v [N_STREAMS];
   logic                  kept;
   logic [CNT_W-1:0]      cur_idx;
   logic [NB_W-1:0]       nbytes;
   logic                  ser_empty;

   assign frag     = mpkt_t'(in_word);
   assign in_ready = ser_empty;
   assign acc      = in_valid && in_ready;
   assign take_v   = acc ? dsel : '0;

   mpr_tag_decode #(.N_STREAMS(N_STREAMS), .SID_W(SID_W)) u_dec (
      .tag    (frag.tag),
      .hit    (hit),
      .sid    (dsid),
      .onehot (dsel)
   );

   generate
      for (genvar s = 0; s < N_STREAMS; s++) begin : g_ctx
         mpr_stream_ctx #(.FRAGS_PER_PKT(FRAGS_PER_PKT), .CNT_W(CNT_W)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take_v[s]),
            .first    (frag.first),
            .seq      (frag.seq),
            .keep     (keep_v[s]),
            .frag_idx (idx_v[s]),
            .loss_ev  (loss_v[s])
         );
      end
   endgenerate

   assign kept    = acc && hit && keep_v[dsid];
   assign cur_idx = idx_v[dsid];
   assign nbytes  = (cur_idx == LAST_IDX) ? NB_W'(LAST_BYTES) : NB_W'(FRAG_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loss_pulse <= '0;
         ovf_pulse  <= '0;
      end else begin
         loss_pulse <= loss_v;
         ovf_pulse  <= take_v & keep_v & {N_STREAMS{frag.dev_ovf}};
      end
   end

   mpr_byte_ser #(.SID_W(SID_W), .FB(FRAG_BYTES), .NB_W(NB_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (kept),
      .pay       (frag.pay),
      .nbytes    (nbytes),
      .sid       (dsid),
      .sop       (cur_idx == '0),
      .eop       (cur_idx == LAST_IDX),
      .empty     (ser_empty),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_byte  (out_byte),
      .out_sid   (out_sid),
      .out_sop   (out_sop),
      .out_eop   (out_eop)
   );

endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
   parameter int N_STREAMS = 4,
   parameter int SID_W     = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [7:0]           out_byte,
   input logic [SID_W-1:0]     out_sid,
   input logic                 out_sop,
   input logic                 out_eop,
   input logic [N_STREAMS-1:0] loss_pulse,
   input logic [N_STREAMS-1:0] ovf_pulse
);

   // R8: the input is held off while a byte waits to leave
   a_r8_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R9: a held byte does not move
   a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) &&
                                     $stable(out_sid) && $stable(out_sop) && $stable(out_eop)));

   // R4: at most one stream reports loss per cycle
   a_r4_loss_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(loss_pulse));

   // R5: at most one stream reports overflow per cycle
   a_r5_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovf_pulse));

   // R4/R5: pulses only follow an accepted word
   a_r5_pulse_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (|loss_pulse || |ovf_pulse) |-> $past(in_valid && in_ready));

   // R7: a packet is never opened and closed on the same byte
   a_r7_sop_eop_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> !out_eop);

endmodule

bind mpkt_ts_rebuild mpr_checker #(.N_STREAMS(N_STREAMS), .SID_W(SID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_byte   (out_byte),
   .out_sid    (out_sid),
   .out_sop    (out_sop),
   .out_eop    (out_eop),
   .loss_pulse (loss_pulse),
   .ovf_pulse  (ovf_pulse)
);

// File: tb/mpkt_ts_rebuild_tb.sv
module mpkt_ts_rebuild_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_byte;
   logic [1:0]  out_sid;
   logic        out_sop;
   logic        out_eop;
   logic [3:0]  loss_pulse;
   logic [3:0]  ovf_pulse;

   always #2 clk = ~clk;   // 250 MHz

   mpkt_ts_rebuild u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_byte(out_byte), .out_sid(out_sid), .out_sop(out_sop),
      .out_eop(out_eop), .loss_pulse(loss_pulse), .ovf_pulse(ovf_pulse)
   );

   int n_chk = 0;
   int n_fail = 0;
   int n_seen = 0;
   int cyc = 0;
   int rdy_mode = 0;    // 0 random, 1 held low, 2 held high

   // bench model of each stream
   int m_idx [4];
   bit m_act [4];
   bit m_seen [4];
   int m_last [4];
   logic [11:0] exp_q [$];

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [31:0] mk(input int tag, input int seq, input bit st,
                                      input bit ovf, input logic [23:0] pay);
      return {3'(tag), 3'(seq), st, ovf, pay};
   endfunction

   // output monitor: handshake seen at negedge happens on the next posedge
   always @(negedge clk) begin
      logic [11:0] got;
      logic [11:0] e;
      case (rdy_mode)
         1: out_ready = 1'b0;
         2: out_ready = 1'b1;
         default: out_ready = ($urandom % 4) != 0;
      endcase
      if (rst_n && out_valid && out_ready) begin
         got = {out_sid, out_sop, out_eop, out_byte};
         n_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected byte", int'(got), 0);
         end else begin
            e = exp_q.pop_front();
            check(got == e, "R2/R6/R7 byte sid/sop/eop", int'(got), int'(e));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         check(1'b0, "watchdog expired", cyc, 0);
         report();
         $finish;
      end
   end

   task automatic send(input logic [31:0] w);
      logic [3:0] el;
      logic [3:0] eo;
      int tg;
      el = '0;
      eo = '0;
      tg = int'(w[31:29]);
      if (tg >= 1 && tg <= 4) begin
         int s;
         bit st;
         s = tg - 1;
         st = w[25];
         if (st || m_act[s]) begin
            int ix;
            int sq;
            int nb;
            ix = st ? 0 : m_idx[s];
            sq = int'(w[28:26]);
            if (m_seen[s] && sq != ((m_last[s] + 1) % 8)) el[s] = 1'b1;
            if (w[24]) eo[s] = 1'b1;
            m_seen[s] = 1'b1;
            m_last[s] = sq;
            nb = (ix == 62) ? 2 : 3;
            for (int b = 0; b < nb; b++) begin
               exp_q.push_back({2'(s), 1'(ix == 0 && b == 0), 1'(ix == 62 && b == nb - 1),
                                w[23 - 8*b -: 8]});
            end
            if (ix == 62) begin
               m_idx[s] = 0;
               m_act[s] = 1'b0;
            end else begin
               m_idx[s] = ix + 1;
               m_act[s] = 1'b1;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(loss_pulse == el, "R4 loss pulse after accept", int'(loss_pulse), int'(el));
      check(ovf_pulse == eo, "R5 overflow pulse after accept", int'(ovf_pulse), int'(eo));
   endtask

   task automatic drain;
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int n0;
      logic [7:0] held;
      void'($urandom(32'd20240611));
      for (int s = 0; s < 4; s++) begin
         m_idx[s] = 0; m_act[s] = 0; m_seen[s] = 0; m_last[s] = 0;
      end
      repeat (4) @(negedge clk);
      // R10: reset state
      check(in_ready == 1'b1, "R10 in_ready in reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(loss_pulse == 4'd0 && ovf_pulse == 4'd0, "R10 pulses after reset",
            int'({loss_pulse, ovf_pulse}), 0);

      // R1: illegal tags are discarded
      n0 = n_seen;
      send(mk(0, 1, 1, 1, 24'h111111));
      send(mk(5, 2, 1, 1, 24'h222222));
      send(mk(6, 3, 1, 0, 24'h333333));
      send(mk(7, 4, 1, 1, 24'h444444));
      drain();
      check(n_seen == n0, "R1 illegal tag produced bytes", n_seen - n0, 0);

      // R3: non-start fragment to an idle stream is discarded (with overflow flag)
      send(mk(2, 0, 0, 1, 24'hABCDEF));
      drain();
      check(n_seen == n0, "R3 idle stream kept a fragment", n_seen - n0, 0);

      // R7/R10: full packet on stream 0, first seq not checked
      n0 = n_seen;
      for (int i = 0; i < 63; i++)
         send(mk(1, (5 + i) % 8, i == 0, 0, {8'(i), 8'(i + 100), 8'(i + 200)}));
      drain();
      check(n_seen - n0 == 188, "R7 bytes in one packet", n_seen - n0, 188);

      // R3: stream 0 is idle again after its last fragment
      n0 = n_seen;
      send(mk(1, 4, 0, 0, 24'h55AA55));
      drain();
      check(n_seen == n0, "R3 stream open after eop", n_seen - n0, 0);

      // R4: sequence break on stream 3
      send(mk(4, 0, 1, 0, 24'h010203));
      send(mk(4, 2, 0, 0, 24'h040506));
      // R5: overflow on a kept fragment of stream 2
      send(mk(3, 6, 1, 1, 24'h0708090));
      // R2: restart stream 3 mid-packet, seq continues
      send(mk(4, 3, 1, 0, 24'hC0FFEE));
      send(mk(4, 4, 0, 0, 24'hBEEF01));
      drain();

      // R8/R9: held output stalls the input and keeps the byte stable
      rdy_mode = 1;
      @(negedge clk);
      send(mk(2, 1, 1, 0, 24'h9A8B7C));
      repeat (3) @(negedge clk);
      held = out_byte;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b0, "R8 in_ready while byte pending", int'(in_ready), 0);
      check(out_valid == 1'b1, "R9 out_valid held", int'(out_valid), 1);
      check(out_byte == 8'h9A && held == 8'h9A, "R9 held byte", int'(out_byte), 'h9A);
      rdy_mode = 2;
      drain();
      rdy_mode = 0;

      // random mix of all streams
      for (int k = 0; k < 3000; k++) begin
         int tg;
         int s;
         int sq;
         bit st;
         tg = ($urandom % 20 == 0) ? int'($urandom % 8) : 1 + int'($urandom % 4);
         s  = (tg >= 1 && tg <= 4) ? tg - 1 : 0;
         st = ($urandom % 30 == 0) || (!m_act[s] && ($urandom % 3 == 0));
         sq = ($urandom % 12 == 0) ? int'($urandom % 8) : (m_last[s] + 1) % 8;
         send(mk(tg, sq, st, ($urandom % 25) == 0, 24'($urandom)));
      end
      drain();
      check(exp_q.size() == 0, "R6 bytes left unsent", exp_q.size(), 0);

      report();
      $finish;
   end

endmodule